// File: doc/BRIEF.md
# Two-Beat Separate-Port Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous SRAM. It has a write data port and a read data port that are separate, and every command moves exactly two words. Commands share one address bus. A command is taken only when the active-low select is low at a rising edge of the main clock. The read/write select picks the operation. Writes are late: their two data beats arrive one main cycle after the command. Reads are pipelined: their two beats leave one main cycle after the command.

Both main-clock edges are modelled with one fast clock `clk` that runs at twice the main rate. The output `rise_half` marks which fast edges stand for rising main edges. Writes carry one enable per 9-bit lane for each beat. A small word array is inside the block. When no read beat is being driven, the read port floats and `rd_valid` is low.

A read address and a write address are held in separate registers. A read can therefore be issued while an earlier write still has late data pending. A write lands in the array at the same edge that captures its data. A read issued right after a write to the same location therefore returns the new words.

Top module: `burst2_sio_sram`

## Requirements
- R1: A command is taken only at a fast edge where `rise_half` is 1 and `sel_n` is 0. `rd_nwr`=1 is a read and `rd_nwr`=0 is a write. `sel_n`, `rd_nwr` and `addr` are ignored at every other fast edge.
- R2: `rise_half` is 1 during reset. After reset it inverts on every fast edge, so the first fast edge after reset release is a rising main edge.
- R3: For a read taken at fast edge E, beat 0 is on `rdata` with `rd_valid`=1 from edge E+2, and beat 1 from edge E+3.
- R4: Beat 0 of a burst uses the command address A. Beat 1 uses A with its bit 0 inverted (A^1), so the pair wraps inside an aligned pair of words.
- R5: For a write taken at fast edge E, beat 0 is taken from `wdata`/`wlane_en` at edge E+2 and stored at A. Beat 1 is taken at edge E+3 and stored at A^1.
- R6: `wlane_en` bit l enables data bits 9*l to 9*l+8. A disabled lane keeps its stored value.
- R7: `wdata` and `wlane_en` are ignored at any fast edge that is not a write beat of R5.
- R8: `rd_valid` is 1 only in the two fast cycles that carry read beats. In every other fast cycle it is 0 and `rdata` is high impedance.
- R9: If select goes high after a read, the two read beats still complete, and `rd_valid` then falls at the next rising edge.
- R10: A read taken at the rising edge just after a write to the same pair returns the newly written words on both beats.
- R11: Back-to-back reads on consecutive rising edges give a valid word in every fast cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at twice the main rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low command select |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Shared command address |
| wdata | input | DATA_W | Write data beat |
| wlane_en | input | DATA_W/9 | Per-lane write enables for the current beat |
| rdata | output | DATA_W | Read data beat, high impedance when idle |
| rd_valid | output | 1 | High while `rdata` carries a read beat |
| rise_half | output | 1 | High when the next fast edge is a rising main edge |

## Verification
Unbroken read streams over even and odd addresses show the beat order and that no fast cycle is left idle. A write followed at once by a read to the same pair shows whether the pipeline ordering forwards the new data or leaks stale words. Partial lane masks and junk on the write port during idle and read cycles separate correct lane gating from stray writes. A read with select dropped just after it, plus a random mix that also toggles the command pins on the falling half, checks burst completion and that falling-half command pins are ignored.

// File: rtl/sb2_pkg.sv
package sb2_pkg;
  localparam int unsigned LANE_BITS = 9;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  function automatic int unsigned lanes_of(input int unsigned width);
    return width / LANE_BITS;
  endfunction
endpackage

// File: rtl/sb2_phase.sv
module sb2_phase (
  input  logic clk,
  input  logic rst_n,
  output logic rise_half
);
  logic rise_half_q;
  logic rise_half_d;

  always_comb begin
    rise_half_d = ~rise_half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_half_q <= 1'b1;
    else        rise_half_q <= rise_half_d;
  end

  assign rise_half = rise_half_q;
endmodule

// File: rtl/sb2_sched.sv
module sb2_sched
  import sb2_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_half,
  input  logic              sel_n,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_wa,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] mem_ra
);
  localparam logic [ADDR_W-1:0] PAIR_FLIP = ADDR_W'(1);

  cmd_e cmd;

  logic              rd_pend_q, rd_pend_d;
  logic              rd_b1_q,   rd_b1_d;
  logic              wr_pend_q, wr_pend_d;
  logic              wr_b1_q,   wr_b1_d;
  logic [ADDR_W-1:0] rd_a_q,    rd_a_d;
  logic [ADDR_W-1:0] rd_b1a_q,  rd_b1a_d;
  logic [ADDR_W-1:0] wr_a_q,    wr_a_d;
  logic [ADDR_W-1:0] wr_b1a_q,  wr_b1a_d;

  // command decode, only on rising-main half
  always_comb begin
    cmd = CMD_NOP;
    if (rise_half && !sel_n) cmd = rd_nwr ? CMD_READ : CMD_WRITE;
  end

  // beat selection for the array ports
  always_comb begin
    if (rise_half) begin
      mem_we  = wr_pend_q;
      mem_wa  = wr_a_q;
      rd_fire = rd_pend_q;
      mem_ra  = rd_a_q;
    end else begin
      mem_we  = wr_b1_q;
      mem_wa  = wr_b1a_q;
      rd_fire = rd_b1_q;
      mem_ra  = rd_b1a_q;
    end
  end

  // next state
  always_comb begin
    rd_pend_d = rd_pend_q;
    wr_pend_d = wr_pend_q;
    rd_b1_d   = 1'b0;
    wr_b1_d   = 1'b0;
    rd_a_d    = rd_a_q;
    wr_a_d    = wr_a_q;
    rd_b1a_d  = rd_b1a_q;
    wr_b1a_d  = wr_b1a_q;
    if (rise_half) begin
      rd_b1_d   = rd_pend_q;
      wr_b1_d   = wr_pend_q;
      rd_b1a_d  = rd_a_q ^ PAIR_FLIP;
      wr_b1a_d  = wr_a_q ^ PAIR_FLIP;
      rd_pend_d = (cmd == CMD_READ);
      wr_pend_d = (cmd == CMD_WRITE);
      if (cmd == CMD_READ)  rd_a_d = addr;
      if (cmd == CMD_WRITE) wr_a_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_b1_q   <= 1'b0;
      wr_pend_q <= 1'b0;
      wr_b1_q   <= 1'b0;
    end else begin
      rd_pend_q <= rd_pend_d;
      rd_b1_q   <= rd_b1_d;
      wr_pend_q <= wr_pend_d;
      wr_b1_q   <= wr_b1_d;
    end
  end

  // address registers carry no reset; qualified by the flags above
  always_ff @(posedge clk) begin
    rd_a_q   <= rd_a_d;
    rd_b1a_q <= rd_b1a_d;
    wr_a_q   <= wr_a_d;
    wr_b1a_q <= wr_b1a_d;
  end
endmodule

// File: rtl/sb2_array.sv
module sb2_array
  import sb2_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 36
) (
  input  logic                                   clk,
  input  logic                                   we,
  input  logic [ADDR_W-1:0]                      waddr,
  input  logic [DATA_W-1:0]                      wdata,
  input  logic [DATA_W/LANE_BITS-1:0]            lane_en,
  input  logic [ADDR_W-1:0]                      raddr,
  output logic [DATA_W-1:0]                      rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LANES = DATA_W / LANE_BITS;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_BITS-1:0] store [DEPTH];
    logic                 lane_we;

    always_comb begin
      lane_we = we && lane_en[l];
    end

    always_ff @(posedge clk) begin
      if (lane_we) store[waddr] <= wdata[l*LANE_BITS +: LANE_BITS];
    end

    assign rdata[l*LANE_BITS +: LANE_BITS] = store[raddr];
  end
endmodule

// File: rtl/sb2_rdout.sv
module sb2_rdout #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] q,
  output logic              q_vld
);
  logic              vld_d;
  logic              q_load;
  logic [DATA_W-1:0] q_q;

  always_comb begin
    vld_d  = rd_fire;
    q_load = rd_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_vld <= 1'b0;
    else        q_vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (q_load) q_q <= arr_data;
  end

  assign q = q_q;
endmodule

// File: rtl/burst2_sio_sram.sv
module burst2_sio_sram
  import sb2_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 36
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_n,
  input  logic                          rd_nwr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [DATA_W/LANE_BITS-1:0]   wlane_en,
  output wire  [DATA_W-1:0]             rdata,
  output logic                          rd_valid,
  output logic                          rise_half
);
  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa;
  logic              rd_fire;
  logic [ADDR_W-1:0] mem_ra;
  logic [DATA_W-1:0] arr_q;
  logic [DATA_W-1:0] out_q;

  sb2_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_half (rise_half)
  );

  sb2_sched #(.ADDR_W(ADDR_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_half (rise_half),
    .sel_n     (sel_n),
    .rd_nwr    (rd_nwr),
    .addr      (addr),
    .mem_we    (mem_we),
    .mem_wa    (mem_wa),
    .rd_fire   (rd_fire),
    .mem_ra    (mem_ra)
  );

  sb2_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_wa),
    .wdata   (wdata),
    .lane_en (wlane_en),
    .raddr   (mem_ra),
    .rdata   (arr_q)
  );

  sb2_rdout #(.DATA_W(DATA_W)) u_rdout (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (rd_fire),
    .arr_data (arr_q),
    .q        (out_q),
    .q_vld    (rd_valid)
  );

  assign rdata = rd_valid ? out_q : {DATA_W{1'bz}};
endmodule

// File: rtl/burst2_sio_sram_chk.sv
module burst2_sio_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic rd_nwr,
  input logic rd_valid,
  input logic rise_half,
  input logic mem_we
);
  logic rd_cmd;
  logic wr_cmd;

  always_comb begin
    rd_cmd = rise_half && !sel_n && rd_nwr;
    wr_cmd = rise_half && !sel_n && !rd_nwr;
  end

  a_r2_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rise_half != $past(rise_half)));

  a_r3_beat0_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> ##2 rd_valid);

  a_r3_beat1_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> ##3 rd_valid);

  a_r3_burst_starts_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> !rise_half);

  a_r8_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_cmd, 3) || $past(rd_cmd, 4)));

  a_r7_write_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (($past(wr_cmd, 2) && rise_half) || ($past(wr_cmd, 3) && !rise_half)));
endmodule

bind burst2_sio_sram burst2_sio_sram_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_n     (sel_n),
  .rd_nwr    (rd_nwr),
  .rd_valid  (rd_valid),
  .rise_half (rise_half),
  .mem_we    (mem_we)
);

// File: tb/burst2_sio_sram_bench.sv
`timescale 1ns/1ps
module burst2_sio_sram_bench;
  localparam int AW = 8;
  localparam int DW = 36;
  localparam int LN = DW / 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n;
  logic          rd_nwr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [LN-1:0] wlane_en;
  wire  [DW-1:0] rdata;
  logic          rd_valid;
  logic          rise_half;

  int checks = 0;
  int errors = 0;
  string tag = "reset";

  logic [DW-1:0] ref_mem [1 << AW];

  // bench-side pipeline expectation state
  logic          rp, rb1, wp, wb1;
  logic [AW-1:0] rp_a, rb1_a, wp_a, wb1_a;
  logic [DW-1:0] wp_d0, wp_d1, wb1_d;
  logic [LN-1:0] wp_m0, wp_m1, wb1_m;
  logic          ev;
  logic [DW-1:0] eq;

  always #2 clk = ~clk;

  burst2_sio_sram #(.ADDR_W(AW), .DATA_W(DW)) u_burst2_sio_sram (
    .clk, .rst_n, .sel_n, .rd_nwr, .addr, .wdata, .wlane_en,
    .rdata, .rd_valid, .rise_half
  );

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LN-1:0] m);
    logic [DW-1:0] r;
    r = old_w;
    for (int l = 0; l < LN; l++)
      if (m[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
    return r;
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic verify(input logic exp_rise);
    chk(rise_half === exp_rise, {tag, " phase flag (R2)"}, 64'(rise_half), 64'(exp_rise));
    chk(rd_valid === ev, {tag, " read valid (R8)"}, 64'(rd_valid), 64'(ev));
    if (ev) chk(rdata === eq, {tag, " read data"}, 64'(rdata), 64'(eq));
  endtask

  // one main cycle: a rising half then a falling half
  task automatic step(input bit en, input bit is_rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [LN-1:0] m0, input logic [LN-1:0] m1);
    sel_n  = !en;
    rd_nwr = is_rd;
    addr   = a;
    if (wp) begin wdata = wp_d0; wlane_en = wp_m0; end
    else    begin wdata = rnd_word(); wlane_en = LN'($urandom()); end
    ev = rp;
    if (rp) eq = ref_mem[rp_a];
    if (wp) ref_mem[wp_a] = merge(ref_mem[wp_a], wp_d0, wp_m0);
    rb1 = rp; rb1_a = rp_a ^ AW'(1);
    wb1 = wp; wb1_a = wp_a ^ AW'(1); wb1_d = wp_d1; wb1_m = wp_m1;
    rp = en && is_rd;  rp_a = a;
    wp = en && !is_rd; wp_a = a;
    wp_d0 = d0; wp_d1 = d1; wp_m0 = m0; wp_m1 = m1;
    @(negedge clk);
    verify(1'b0);
    // falling half: command pins carry junk (R1)
    sel_n  = $urandom();
    rd_nwr = $urandom();
    addr   = AW'($urandom());
    if (wb1) begin wdata = wb1_d; wlane_en = wb1_m; end
    else     begin wdata = rnd_word(); wlane_en = LN'($urandom()); end
    ev = rb1;
    if (rb1) eq = ref_mem[rb1_a];
    if (wb1) ref_mem[wb1_a] = merge(ref_mem[wb1_a], wb1_d, wb1_m);
    @(negedge clk);
    verify(1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, '0, '0, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(1'b1, 1'b1, a, '0, '0, '0, '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d0,
                    input logic [DW-1:0] d1, input logic [LN-1:0] m0,
                    input logic [LN-1:0] m1);
    step(1'b1, 1'b0, a, d0, d1, m0, m1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired in section %s", tag);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rp = 0; rb1 = 0; wp = 0; wb1 = 0; ev = 0; eq = '0;
    rp_a = '0; rb1_a = '0; wp_a = '0; wb1_a = '0;
    wp_d0 = '0; wp_d1 = '0; wb1_d = '0; wp_m0 = '0; wp_m1 = '0; wb1_m = '0;
    rst_n = 1'b0; sel_n = 1'b1; rd_nwr = 1'b0; addr = '0; wdata = '0; wlane_en = '0;
    repeat (4) @(negedge clk);
    tag = "R2 R8 reset state";
    chk(rise_half === 1'b1, "R2 reset phase flag", 64'(rise_half), 64'd1);
    chk(rd_valid === 1'b0, "R8 reset valid low", 64'(rd_valid), 64'd0);
    rst_n = 1'b1;

    tag = "R5 full write preload";
    for (int a = 0; a < 16; a += 2) wr(AW'(a), rnd_word(), rnd_word(), '1, '1);
    idle(2);

    tag = "R11 back-to-back reads";
    for (int a = 0; a < 16; a += 2) rd(AW'(a));
    idle(2);

    tag = "R4 odd address wrap order";
    rd(8'd5); rd(8'd10); rd(8'd3);
    idle(2);

    tag = "R10 read right after write";
    wr(8'd6, rnd_word(), rnd_word(), '1, '1);
    rd(8'd6);
    wr(8'd9, rnd_word(), rnd_word(), '1, '1);
    rd(8'd8);
    idle(2);

    tag = "R6 lane masked write";
    wr(8'd12, rnd_word(), rnd_word(), 4'b0101, 4'b1010);
    wr(8'd2, rnd_word(), rnd_word(), 4'b0000, 4'b1000);
    idle(1);
    rd(8'd12); rd(8'd2);
    idle(2);

    tag = "R7 junk on write port while idle";
    idle(6);
    rd(8'd0); rd(8'd4); rd(8'd14);
    idle(2);

    tag = "R9 deselect after read";
    rd(8'd7);
    idle(3);
    rd(8'd1); rd(8'd11);
    idle(3);

    tag = "R1 R3 random mix";
    for (int i = 0; i < 600; i++) begin
      int kind;
      kind = int'($urandom_range(0, 9));
      if (kind < 3)      idle(1);
      else if (kind < 7) rd(AW'($urandom_range(0, 15)));
      else               wr(AW'($urandom_range(0, 15)), rnd_word(), rnd_word(),
                            LN'($urandom()), LN'($urandom()));
    end
    idle(3);
    finish_run();
  end
endmodule